// File: doc/BRIEF.md
# Latched Status Register Bank

This block is the read side of a motor-driver control port. It collects pre-digitised fault pulses, undervoltage levels and measurement values. Some are held in sticky flags and some are passed straight through as live bits. It answers a 5-bit register address with one status byte. Seven of the eight register slots protect their byte with an odd parity bit in bit 7. Reading a register clears the sticky flags it holds. Two summary bits in the error register show the state of the per-axis short and open flags without disturbing them. The bank also checks the framing of the serial port itself. It counts rising clock edges while the select line is low, and it raises a sticky error when a frame ends on a count that is not a whole number of words.

Read requests use a valid/ready pair, and so do the responses. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The byte comes out on `resp_data` with `resp_valid` on the following cycle. It stays there, unchanged, until `resp_ready` is high at a clock edge. `req_ready` is low only while a response is waiting and `resp_ready` is low. A request that is not accepted clears nothing. The serial select and clock are inputs already synchronous to `clk`.

Top module: `stat_bank`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are high at an edge. `resp_valid` rises the next cycle. `resp_data` is held stable while `resp_valid` is high and `resp_ready` is low, and `req_ready` is low during that time.
- R2: For every mapped offset except 4, bit 7 of the byte is odd parity over bits 6..0, so the byte always has an odd number of ones. Offset 4 (speed) carries 8 data bits and no parity.
- R3: An address with bit 3 set is mapped, and bits 2..0 give the offset. Offsets 0 to 5 give the same byte whether bit 4 is 0 or 1. Offsets 6 and 7 return the x/y PWM words (bits 6..0) when bit 4 is 0, and the x/y pin-and-short bytes when bit 4 is 1. An address with bit 3 clear returns 0x00 and clears nothing.
- R4: The error register (offset 0) holds the following bits. Bit 6 is the frame error (sticky). Bit 5 is the short summary and bit 4 is the open summary. Bit 3 is thermal shutdown (sticky). Bit 2 is thermal warning (live). Bit 1 is stall (sticky). Bit 0 is the hard-reset flag (sticky).
- R5: A sticky flag is set by its input and stays set until an accepted read of its own register.
- R6: If a setting event and a clearing read of the same flag fall in the same cycle, the flag stays set. The byte returned by that read still shows the state from before the event.
- R7: The short summary is the OR of all eight per-axis short flags, and the open summary is the OR of the two open flags. Reading offset 0 clears neither the summary bits nor the per-axis flags.
- R8: In offset 1, bit 6 is the OR of bits 6..0 of offset 0 as they stood before that cycle's clear. Bit 5 is the live BEMF-ready input. Bits 4..0 are sticky flags: UV1, UV2, UV2-in-motion, UV3, UV3-in-motion.
- R9: An in-motion undervoltage flag is set only by a step pulse that arrives while its undervoltage level is high.
- R10: The frame error is set when the select line rises after a number of clock rising edges that is not a multiple of FRAME_LEN. It is visible to a read two cycles after the select line rises.
- R11: After reset, offset 0 reads 0x01, offset 1 reads 0xDA (low bits 1011010), and the speed register reads 0xFF until the first edge after reset.
- R12: Offset 5 holds a 7-bit step-loss value. The value is loaded by a strobe and cleared to zero by a read, and a load in the same cycle as a read wins. Offsets 2, 3 and 6/7 (bit 4 clear) pass live 7-bit fields.
- R13: The byte at 0x1E holds open-x (sticky) in bit 6, the live step0 and step1 pins in bits 5 and 4, and the sticky x short flags in bits 3..0. The byte at 0x1F holds the same layout for y, with the RHB and DIR pins in bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial select, low during a frame |
| sclk | input | 1 | Serial clock, sampled |
| ev_thermal_sd | input | 1 | Thermal shutdown event |
| thermal_warn | input | 1 | Thermal warning level |
| ev_stall | input | 1 | Stall event |
| short_x | input | 4 | X-axis short events |
| short_y | input | 4 | Y-axis short events |
| open_x | input | 1 | X open-coil event |
| open_y | input | 1 | Y open-coil event |
| uv1_lvl | input | 1 | Undervoltage 1 level |
| uv2_lvl | input | 1 | Undervoltage 2 level |
| uv3_lvl | input | 1 | Undervoltage 3 level |
| step_pulse | input | 1 | Step pulse |
| bemf_ready | input | 1 | BEMF result ready |
| bemf_value | input | 7 | BEMF value |
| ustep_pos | input | 7 | Microstep position |
| speed_in | input | 8 | Speed value |
| sl_load | input | 1 | Step-loss load strobe |
| sl_value | input | 7 | Step-loss value |
| pwm_x | input | 7 | X PWM word |
| pwm_y | input | 7 | Y PWM word |
| pin_step0 | input | 1 | Step0 pin level |
| pin_step1 | input | 1 | Step1 pin level |
| pin_rhb | input | 1 | RHB pin level |
| pin_dir | input | 1 | Direction pin level |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_addr | input | 5 | Read address |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response ready |
| resp_data | output | 8 | Response byte |

## Verification
The bench uses the default FRAME_LEN of 16. At that value, frames of 15, 16 and 32 edges put both the wrap of the edge counter and the "not a multiple" error within a few hundred cycles. The table walk reads every mapped slot at both aliases after reset. Directed tests then cover the following cases:
- a set and a clearing read in the same cycle;
- the summary bits surviving a read;
- a stalled response against a waiting request;
- the speed reset value seen on the first edge after reset.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = BYTE_W - 1;
  localparam int SHORT_W = 4;
  localparam int ADDR_W  = 5;

  typedef enum logic [2:0] {
    OFS_ERR   = 3'd0,
    OFS_UV    = 3'd1,
    OFS_USTEP = 3'd2,
    OFS_BEMF  = 3'd3,
    OFS_SPEED = 3'd4,
    OFS_SLOSS = 3'd5,
    OFS_XSLOT = 3'd6,
    OFS_YSLOT = 3'd7
  } ofs_e;

  function automatic logic [BYTE_W-1:0] with_par(input logic [FIELD_W-1:0] d);
    return {~^d, d};
  endfunction
endpackage

// File: rtl/stat_frame_chk.sv
module stat_frame_chk #(
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic frame_err
);
  localparam int CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic             cs_q, sclk_q;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = sclk & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n)
        cnt <= '0;
      else if (rise)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign frame_err = cs_n & ~cs_q & (cnt != '0);
endmodule

// File: rtl/stat_flag_latch.sv
module stat_flag_latch #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q & ~{W{clr}}) | set;
  end
endmodule

// File: rtl/stat_resp_port.sv
module stat_resp_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] rd_byte,
  output logic         accept,
  output logic         resp_valid,
  input  logic         resp_ready,
  output logic [W-1:0] resp_data
);
  assign req_ready = ~resp_valid | resp_ready;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_data  <= rd_byte;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int           FRAME_LEN = 16,
  parameter logic [7:0]   SPEED_RST = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 ev_thermal_sd,
  input  logic                 thermal_warn,
  input  logic                 ev_stall,
  input  logic [SHORT_W-1:0]   short_x,
  input  logic [SHORT_W-1:0]   short_y,
  input  logic                 open_x,
  input  logic                 open_y,
  input  logic                 uv1_lvl,
  input  logic                 uv2_lvl,
  input  logic                 uv3_lvl,
  input  logic                 step_pulse,
  input  logic                 bemf_ready,
  input  logic [FIELD_W-1:0]   bemf_value,
  input  logic [FIELD_W-1:0]   ustep_pos,
  input  logic [BYTE_W-1:0]    speed_in,
  input  logic                 sl_load,
  input  logic [FIELD_W-1:0]   sl_value,
  input  logic [FIELD_W-1:0]   pwm_x,
  input  logic [FIELD_W-1:0]   pwm_y,
  input  logic                 pin_step0,
  input  logic                 pin_step1,
  input  logic                 pin_rhb,
  input  logic                 pin_dir,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic [BYTE_W-1:0]    resp_data
);
  localparam int AX_W = SHORT_W + 1;

  logic        accept, frame_err, mapped;
  ofs_e        ofs;
  logic [BYTE_W-1:0] rd_byte;

  assign mapped = req_addr[3];
  assign ofs    = ofs_e'(req_addr[2:0]);

  stat_frame_chk #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .frame_err(frame_err)
  );

  // error flags: {frame, thermal shutdown, stall, hard reset}
  logic [3:0] err_q;
  stat_flag_latch #(.W(4), .RST_VAL(4'b0001)) u_err (
    .clk(clk), .rst_n(rst_n),
    .set({frame_err, ev_thermal_sd, ev_stall, 1'b0}),
    .clr(accept & mapped & (ofs == OFS_ERR)),
    .q(err_q)
  );

  // undervoltage flags: {uv1, uv2, uv2 motion, uv3, uv3 motion}
  logic [4:0] uv_q;
  stat_flag_latch #(.W(5), .RST_VAL(5'b11010)) u_uv (
    .clk(clk), .rst_n(rst_n),
    .set({uv1_lvl, uv2_lvl, uv2_lvl & step_pulse, uv3_lvl, uv3_lvl & step_pulse}),
    .clr(accept & mapped & (ofs == OFS_UV)),
    .q(uv_q)
  );

  // per-axis flags: {open, shorts}
  logic [1:0][AX_W-1:0] ax_set, ax_q;
  logic [1:0]           ax_clr;
  assign ax_set[0] = {open_x, short_x};
  assign ax_set[1] = {open_y, short_y};

  for (genvar g = 0; g < 2; g++) begin : g_axis
    assign ax_clr[g] = accept & (req_addr == {1'b1, 1'b1, 2'b11, g[0]});
    stat_flag_latch #(.W(AX_W), .RST_VAL('0)) u_ax (
      .clk(clk), .rst_n(rst_n), .set(ax_set[g]), .clr(ax_clr[g]), .q(ax_q[g])
    );
  end

  logic [FIELD_W-1:0] sl_q;
  logic [BYTE_W-1:0]  speed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_q    <= '0;
      speed_q <= SPEED_RST;
    end else begin
      speed_q <= speed_in;
      if (sl_load)
        sl_q <= sl_value;
      else if (accept & mapped & (ofs == OFS_SLOSS))
        sl_q <= '0;
    end
  end

  logic [FIELD_W-1:0] err_field;
  assign err_field = {err_q[3],
                      |{ax_q[1][SHORT_W-1:0], ax_q[0][SHORT_W-1:0]},
                      ax_q[1][SHORT_W] | ax_q[0][SHORT_W],
                      err_q[2], thermal_warn, err_q[1], err_q[0]};

  always_comb begin
    rd_byte = '0;
    if (mapped) begin
      unique case (ofs)
        OFS_ERR:   rd_byte = with_par(err_field);
        OFS_UV:    rd_byte = with_par({|err_field, bemf_ready, uv_q});
        OFS_USTEP: rd_byte = with_par(ustep_pos);
        OFS_BEMF:  rd_byte = with_par(bemf_value);
        OFS_SPEED: rd_byte = speed_q;
        OFS_SLOSS: rd_byte = with_par(sl_q);
        OFS_XSLOT: rd_byte = req_addr[4]
                     ? with_par({ax_q[0][SHORT_W], pin_step0, pin_step1, ax_q[0][SHORT_W-1:0]})
                     : with_par(pwm_x);
        OFS_YSLOT: rd_byte = req_addr[4]
                     ? with_par({ax_q[1][SHORT_W], pin_rhb, pin_dir, ax_q[1][SHORT_W-1:0]})
                     : with_par(pwm_y);
        default:   rd_byte = '0;
      endcase
    end
  end

  stat_resp_port #(.W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_byte(rd_byte), .accept(accept), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data)
  );
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [4:0] req_addr,
  input logic       resp_valid,
  input logic       resp_ready,
  input logic [7:0] resp_data
);
  // R1
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R1
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready && !req_ready) |=> ($stable(resp_data) && resp_valid));

  // R1
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);

  // R2
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[3] && req_addr[2:0] != 3'd4) |=> (^resp_data));

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_addr[3]) |=> (resp_data == 8'h00));
endmodule

bind stat_bank stat_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_data(resp_data)
);

// File: tb/sim_stat_bank.sv
`timescale 1ns/1ps
module sim_stat_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0;
  logic ev_thermal_sd = 0, thermal_warn = 0, ev_stall = 0;
  logic [3:0] short_x = 0, short_y = 0;
  logic open_x = 0, open_y = 0;
  logic uv1_lvl = 0, uv2_lvl = 0, uv3_lvl = 0, step_pulse = 0;
  logic bemf_ready = 0;
  logic [6:0] bemf_value = 7'h3F, ustep_pos = 7'h15;
  logic [7:0] speed_in = 8'hA5;
  logic sl_load = 0;
  logic [6:0] sl_value = 0, pwm_x = 7'h12, pwm_y = 7'h7F;
  logic pin_step0 = 0, pin_step1 = 0, pin_rhb = 0, pin_dir = 0;
  logic req_valid = 0, resp_ready = 1;
  logic [4:0] req_addr = 0;
  logic req_ready, resp_valid;
  logic [7:0] resp_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_bank u0 (.*);

  // {address, expected byte}, walked right after reset
  localparam logic [12:0] VEC [15] = '{
    {5'h09, 8'hDA}, {5'h08, 8'h01}, {5'h08, 8'h80}, {5'h19, 8'h80},
    {5'h0A, 8'h15}, {5'h1A, 8'h15}, {5'h0B, 8'hBF}, {5'h0C, 8'hA5},
    {5'h1C, 8'hA5}, {5'h0D, 8'h80}, {5'h0E, 8'h92}, {5'h0F, 8'h7F},
    {5'h1E, 8'h80}, {5'h1F, 8'h80}, {5'h03, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
    d = resp_valid ? resp_data : 8'hxx;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic frame(input int n);
    @(negedge clk); cs_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1;
      @(negedge clk); sclk = 0;
    end
    @(negedge clk); cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_stall();
    @(negedge clk); ev_stall = 1;
    @(negedge clk); ev_stall = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 R3 R2 R12: reset state and address walk
    for (int i = 0; i < 15; i++)
      rd_chk("R3/R11 table", VEC[i][12:8], VEC[i][7:0]);

    // R5 sticky stall, cleared by read
    pulse_stall();
    rd_chk("R5 stall set", 5'h08, 8'h02);
    rd_chk("R5 stall cleared", 5'h08, 8'h80);

    // R4 thermal warning is live
    @(negedge clk); thermal_warn = 1;
    rd_chk("R4 warn live", 5'h08, 8'h04);
    rd_chk("R4 warn survives read", 5'h08, 8'h04);
    @(negedge clk); thermal_warn = 0;
    rd_chk("R4 warn gone", 5'h08, 8'h80);

    // R4 thermal shutdown sticky
    @(negedge clk); ev_thermal_sd = 1;
    @(negedge clk); ev_thermal_sd = 0;
    rd_chk("R4 tsd", 5'h18, 8'h08);

    // R7 R13 R8 summary bits
    @(negedge clk); short_x = 4'b0100;
    @(negedge clk); short_x = 0;
    rd_chk("R7 short summary", 5'h08, 8'h20);
    rd_chk("R7 summary not cleared", 5'h08, 8'h20);
    rd_chk("R8 or of error bits", 5'h09, 8'h40);
    rd_chk("R13 x shorts", 5'h1E, 8'h04);
    rd_chk("R7 summary follows clear", 5'h08, 8'h80);
    @(negedge clk); open_y = 1;
    @(negedge clk); open_y = 0;
    rd_chk("R7 open summary", 5'h08, 8'h10);
    rd_chk("R13 y open", 5'h1F, 8'h40);
    rd_chk("R13 y open cleared", 5'h1F, 8'h80);
    @(negedge clk); pin_step0 = 1; pin_rhb = 1;
    rd_chk("R13 step0 pin", 5'h1E, 8'h20);
    rd_chk("R13 rhb pin", 5'h1F, 8'h20);
    @(negedge clk); pin_step0 = 0; pin_rhb = 0;

    // R8 bemf ready live
    @(negedge clk); bemf_ready = 1;
    rd_chk("R8 bemf ready", 5'h09, 8'h20);
    @(negedge clk); bemf_ready = 0;

    // R9 motion undervoltage
    @(negedge clk); uv2_lvl = 1;
    @(negedge clk); uv2_lvl = 0;
    rd_chk("R9 uv2 alone", 5'h09, 8'h08);
    @(negedge clk); uv2_lvl = 1; step_pulse = 1;
    @(negedge clk); uv2_lvl = 0; step_pulse = 0;
    rd_chk("R9 uv2 motion", 5'h09, 8'h8C);
    @(negedge clk); step_pulse = 1;
    @(negedge clk); step_pulse = 0;
    rd_chk("R9 step without uv", 5'h09, 8'h80);
    @(negedge clk); uv3_lvl = 1; step_pulse = 1;
    @(negedge clk); uv3_lvl = 0; step_pulse = 0;
    rd_chk("R9 uv3 motion", 5'h19, 8'h83);

    // R6 event in same cycle as clearing read
    @(negedge clk);
    req_valid = 1; req_addr = 5'h08; ev_stall = 1;
    @(posedge clk); #1;
    req_valid = 0; ev_stall = 0;
    check("R6 read shows old state", resp_data, 8'h80);
    rd_chk("R6 flag kept", 5'h08, 8'h02);

    // R10 frame length
    frame(16);
    rd_chk("R10 16 edges ok", 5'h08, 8'h80);
    frame(15);
    rd_chk("R10 15 edges error", 5'h08, 8'h40);
    frame(32);
    rd_chk("R10 32 edges ok", 5'h08, 8'h80);

    // R12 step-loss load and clear
    @(negedge clk); sl_load = 1; sl_value = 7'h33;
    @(negedge clk); sl_load = 0;
    rd_chk("R12 step loss", 5'h1D, 8'hB3);
    rd_chk("R12 step loss cleared", 5'h0D, 8'h80);

    // R1 R5 back-pressure: unaccepted request clears nothing
    pulse_stall();
    @(negedge clk); resp_ready = 0; req_valid = 1; req_addr = 5'h0A;
    @(posedge clk); #1;
    req_addr = 5'h08;
    check("R1 first response", resp_data, 8'h15);
    @(negedge clk);
    check("R1 ready low", {7'd0, req_ready}, 8'h00);
    @(negedge clk);
    check("R1 data held", resp_data, 8'h15);
    req_valid = 0; resp_ready = 1;
    @(negedge clk);
    rd_chk("R5 not cleared by refused request", 5'h08, 8'h02);

    // R11 speed reset value on first edge after reset
    @(negedge clk); rst_n = 0;
    req_valid = 1; req_addr = 5'h0C;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    req_valid = 0;
    check("R11 speed reset", resp_data, 8'hFF);
    rd_chk("R11 speed follows input", 5'h0C, 8'hA5);
    rd_chk("R11 hard reset flag", 5'h08, 8'h01);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule